// File: doc/BRIEF.md
# DMA Buffer Address Pointer Unit

This block holds the buffer-side address of every channel of a small DMA controller. Each channel owns one 24-bit pointer that covers a 16 MiB space. Software reaches the pointer one byte at a time through three register slots, for the low, middle and high bytes. It reads back the selected byte in the same cycle.

When a transfer completes, the controller pulses a done strobe. The strobe carries the channel index, the transfer size and the channel's hold/advance bit. If the bit selects advance, the low 16 bits of that channel's pointer step by 1 for a byte or by 2 for a word. The high byte never moves, so the pointer wraps inside its 64 KiB bank. If the bit selects hold, the pointer keeps its value.

A separate select picks one channel's full pointer and drives it onto the current-address output for the bus side. Reset gives the pointers no defined value, so software loads each pointer before it is used.

Top module: `dbap_unit`

## Requirements
- R1: Each channel has its own 24-bit pointer. A write or a transfer addressed to one channel leaves every other channel's pointer unchanged, and a pointer with no write and no transfer keeps its value.
- R2: A register write with lane code 0 loads bits 7:0, lane code 1 loads bits 15:8 and lane code 2 loads bits 23:16 of the selected channel's pointer. The write takes effect at the next clock edge, and the other two bytes stay unchanged.
- R3: The read data shows, in the same cycle, the byte of the selected channel that the lane code picks (0 for bits 7:0, 1 for 15:8, 2 for 23:16). Lane code 3 reads as 0x00, and a write with lane code 3 changes no pointer.
- R4: A done strobe with the advance bit set to 1 and the size flag set to 0 (byte) adds 1 to bits 15:0 of that channel's pointer at the next edge.
- R5: A done strobe with the advance bit set to 1 and the size flag set to 1 (word) adds 2 to bits 15:0 of that channel's pointer at the next edge.
- R6: A done strobe with the advance bit set to 0 leaves the pointer unchanged, for either size.
- R7: A carry out of bit 15 is dropped, so bits 15:0 wrap modulo 65536. Bits 23:16 never change because of a transfer; for example, 0x12FFFF advanced by a byte gives 0x120000.
- R8: If a write on lanes 0 to 2 and a done strobe name the same channel in the same cycle, only the write takes effect. If they name different channels, both take effect.
- R9: The current-address output always shows the full 24-bit pointer of the channel named by the address select, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; pointers become undefined |
| reg_chan | input | CH_W | Channel addressed by the register port |
| reg_lane | input | 2 | Byte lane: 0 low, 1 middle, 2 high, 3 unused |
| reg_wdata | input | 8 | Write data byte |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Same-cycle read of the addressed byte |
| done_vld | input | 1 | One-cycle strobe per completed transfer |
| done_chan | input | CH_W | Channel that completed a transfer |
| done_word | input | 1 | Transfer size: 0 byte, 1 word |
| done_adv | input | 1 | Advance (1) or hold (0) the pointer |
| addr_sel | input | CH_W | Channel shown on the current-address output |
| cur_addr | output | 24 | Full pointer of the selected channel |

## Verification
The bench builds the unit with its default of four channels (CH_W = 2). At that size it can visit every channel, every lane code and every pairing of size with the advance bit. For each channel it starts from low-half values at and around both the 0x7FFF/0x8000 boundary and the 0xFFFF wrap, with a different high byte per channel, so that a carry leaking into bits 23:16 shows up at once. Collision cases pair a write with a done strobe on the same channel and on a different channel, and a reference model in the bench tracks all four pointers so that any effect on a channel that was not addressed is caught.

// File: rtl/dbap_pkg.sv
package dbap_pkg;

    localparam int ADDR_W = 24;
    localparam int BANK_W = 16;
    localparam int BYTE_W = 8;

    typedef logic [ADDR_W-1:0] ptr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        LANE_LO  = 2'd0,
        LANE_MID = 2'd1,
        LANE_HI  = 2'd2,
        LANE_RSV = 2'd3
    } lane_e;

    typedef struct packed {
        logic vld;
        logic word;
        logic adv;
    } done_t;

    // Step size in the bank for one completed transfer.
    function automatic logic [BANK_W-1:0] step_of(logic word);
        return word ? BANK_W'(2) : BANK_W'(1);
    endfunction

endpackage

// File: rtl/dbap_lane_port.sv
module dbap_lane_port
    import dbap_pkg::*;
(
    input  ptr_t  cur,
    input  lane_e lane,
    input  byte_t wdata,
    output ptr_t  merged,
    output byte_t rbyte,
    output logic  lane_ok
);
    always_comb begin
        merged  = cur;
        rbyte   = '0;
        lane_ok = 1'b1;
        unique case (lane)
            LANE_LO: begin
                merged[7:0] = wdata;
                rbyte       = cur[7:0];
            end
            LANE_MID: begin
                merged[15:8] = wdata;
                rbyte        = cur[15:8];
            end
            LANE_HI: begin
                merged[23:16] = wdata;
                rbyte         = cur[23:16];
            end
            default: lane_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbap_step.sv
module dbap_step
    import dbap_pkg::*;
(
    input  ptr_t  cur,
    input  done_t ev,
    output ptr_t  nxt
);
    logic [BANK_W-1:0] low_sum;

    // Carry out of the bank is discarded on purpose.
    assign low_sum = cur[BANK_W-1:0] + step_of(ev.word);

    always_comb begin
        nxt = cur;
        if (ev.vld && ev.adv)
            nxt = {cur[ADDR_W-1:BANK_W], low_sum};
    end
endmodule

// File: rtl/dbap_chan.sv
module dbap_chan
    import dbap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hit,
    input  lane_e lane,
    input  byte_t wdata,
    input  done_t ev,
    output ptr_t  ptr,
    output byte_t rbyte
);
    ptr_t ptr_q;
    ptr_t merged;
    ptr_t stepped;
    logic lane_ok;
    logic wr_take;

    dbap_lane_port u_lane (
        .cur     (ptr_q),
        .lane    (lane),
        .wdata   (wdata),
        .merged  (merged),
        .rbyte   (rbyte),
        .lane_ok (lane_ok)
    );

    dbap_step u_step (
        .cur (ptr_q),
        .ev  (ev),
        .nxt (stepped)
    );

    assign wr_take = wr_hit && lane_ok;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= 'x;
        else if (wr_take)
            ptr_q <= merged;
        else
            ptr_q <= stepped;
    end

    assign ptr = ptr_q;

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && !ev.vld) |=> $stable(ptr_q));

    p_hi_lane_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && lane == LANE_HI) |=> (ptr_q[23:16] == $past(wdata)
                                         && ptr_q[15:0] == $past(ptr_q[15:0])));

    p_rsv_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && lane == LANE_RSV && !ev.vld) |=> $stable(ptr_q));

    p_byte_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_take && ev.vld && ev.adv && !ev.word)
        |=> ptr_q[15:0] == $past(ptr_q[15:0]) + 16'd1);

    p_word_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_take && ev.vld && ev.adv && ev.word)
        |=> ptr_q[15:0] == $past(ptr_q[15:0]) + 16'd2);

    p_fix_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && ev.vld && !ev.adv) |=> $stable(ptr_q));

    p_bank_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && ev.vld) |=> $stable(ptr_q[23:16]));

    p_sw_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && lane == LANE_LO && ev.vld)
        |=> (ptr_q[7:0] == $past(wdata) && ptr_q[23:8] == $past(ptr_q[23:8])));
endmodule

// File: rtl/dbap_unit.sv
module dbap_unit
    import dbap_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CH_W-1:0] reg_chan,
    input  logic [1:0]      reg_lane,
    input  logic [7:0]      reg_wdata,
    input  logic            reg_we,
    output logic [7:0]      reg_rdata,
    input  logic            done_vld,
    input  logic [CH_W-1:0] done_chan,
    input  logic            done_word,
    input  logic            done_adv,
    input  logic [CH_W-1:0] addr_sel,
    output logic [23:0]     cur_addr
);
    ptr_t  ptrs  [NCH];
    byte_t bytes [NCH];
    lane_e lane;

    assign lane = lane_e'(reg_lane);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic  wr_hit;
        done_t ev;

        assign wr_hit  = reg_we && (reg_chan == CH_W'(c));
        assign ev.vld  = done_vld && (done_chan == CH_W'(c));
        assign ev.word = done_word;
        assign ev.adv  = done_adv;

        dbap_chan u_ch (
            .clk   (clk),
            .rst   (rst),
            .wr_hit(wr_hit),
            .lane  (lane),
            .wdata (reg_wdata),
            .ev    (ev),
            .ptr   (ptrs[c]),
            .rbyte (bytes[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        cur_addr  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (reg_chan == CH_W'(c)) reg_rdata = bytes[c];
            if (addr_sel == CH_W'(c)) cur_addr  = ptrs[c];
        end
    end

    always_comb begin
        if (!rst && reg_lane == 2'd3)
            a_rsv_reads_zero_r3: assert (reg_rdata == 8'h00);
    end
endmodule

// File: tb/sim_dbap_unit.sv
module sim_dbap_unit;
    localparam int NCH  = 4;
    localparam int CH_W = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CH_W-1:0] reg_chan = '0;
    logic [1:0]      reg_lane = '0;
    logic [7:0]      reg_wdata = '0;
    logic            reg_we = 1'b0;
    logic [7:0]      reg_rdata;
    logic            done_vld = 1'b0;
    logic [CH_W-1:0] done_chan = '0;
    logic            done_word = 1'b0;
    logic            done_adv = 1'b0;
    logic [CH_W-1:0] addr_sel = '0;
    logic [23:0]     cur_addr;

    int checks = 0;
    int fails  = 0;
    logic [23:0] model [NCH];

    always #4 clk = ~clk;

    dbap_unit #(.NCH(NCH), .CH_W(CH_W)) u0 (.*);

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    // One clock with the given strobes; strobes drop 2 ns after the edge.
    task automatic cyc();
        @(posedge clk);
        #2;
        reg_we   = 1'b0;
        done_vld = 1'b0;
    endtask

    task automatic put(input int ch, input int ln, input logic [7:0] d);
        reg_chan = CH_W'(ch); reg_lane = 2'(ln); reg_wdata = d; reg_we = 1'b1;
        if (ln < 3) model[ch][ln*8 +: 8] = d;
        cyc();
    endtask

    task automatic load(input int ch, input logic [23:0] v);
        for (int l = 0; l < 3; l++) put(ch, l, v[l*8 +: 8]);
    endtask

    function automatic logic [23:0] adv(input logic [23:0] p, input logic w);
        return {p[23:16], 16'(p[15:0] + (w ? 16'd2 : 16'd1))};
    endfunction

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            addr_sel = CH_W'(c);
            #0.5;
            chk(req, cur_addr, model[c]);
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lows [6];
        lows = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R2, R1: load distinct pointers, channel by channel, lane by lane
        for (int c = 0; c < NCH; c++) load(c, 24'h10_2030 + 24'(c) * 24'h11_0101);
        check_all("R2");

        // R3: same-cycle reads of every lane
        for (int c = 0; c < NCH; c++)
            for (int l = 0; l < 4; l++) begin
                reg_chan = CH_W'(c); reg_lane = 2'(l);
                #0.5;
                chk("R3", {16'h0, reg_rdata}, {16'h0, (l < 3) ? model[c][l*8 +: 8] : 8'h00});
            end

        // R3: lane 3 write changes nothing
        reg_chan = 2'd1; reg_lane = 2'd3; reg_wdata = 8'hA5; reg_we = 1'b1;
        cyc();
        check_all("R3");

        // R4 R5 R6 R7: sweep sizes, advance bit and bank edges per channel
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < 6; i++)
                for (int m = 0; m < 4; m++) begin
                    load(c, {8'(8'hC0 + c), lows[i]});
                    done_chan = CH_W'(c); done_word = m[0]; done_adv = m[1]; done_vld = 1'b1;
                    if (m[1]) model[c] = adv(model[c], m[0]);
                    cyc();
                    addr_sel = CH_W'(c);
                    #0.5;
                    chk(m[1] ? (m[0] ? "R5/R7" : "R4/R7") : "R6", cur_addr, model[c]);
                end
        check_all("R1");

        // R7: explicit wrap example
        load(2, 24'h12_FFFF);
        done_chan = 2'd2; done_word = 1'b0; done_adv = 1'b1; done_vld = 1'b1;
        cyc();
        addr_sel = 2'd2; #0.5;
        chk("R7", cur_addr, 24'h12_0000);
        model[2] = 24'h12_0000;

        // R8: write and advance on the same channel - write only
        load(3, 24'h34_00FF);
        reg_chan = 2'd3; reg_lane = 2'd1; reg_wdata = 8'h77; reg_we = 1'b1;
        done_chan = 2'd3; done_word = 1'b1; done_adv = 1'b1; done_vld = 1'b1;
        model[3] = 24'h34_77FF;
        cyc();
        check_all("R8");

        // R8: write and advance on different channels - both apply
        load(0, 24'h01_FFFF);
        reg_chan = 2'd1; reg_lane = 2'd0; reg_wdata = 8'h5A; reg_we = 1'b1;
        model[1][7:0] = 8'h5A;
        done_chan = 2'd0; done_word = 1'b1; done_adv = 1'b1; done_vld = 1'b1;
        model[0] = 24'h01_0001;
        cyc();
        check_all("R8");

        // R9: select switches the output with no clock
        for (int c = NCH - 1; c >= 0; c--) begin
            addr_sel = CH_W'(c);
            #0.5;
            chk("R9", cur_addr, model[c]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule